// File: doc/BRIEF.md
# Hashed Set-Associative Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It holds a set-associative cache of branch targets. Each way of each set keeps a valid bit, a tag taken from the branch address, and a full target address. The fetch side sends a lookup request with a branch address, a global history value and up to three recent indirect targets. One cycle later the block answers with a hit flag and the predicted target.

The set is chosen by a hash and the tag is not. The hash starts from the branch address with the instruction-offset bits removed. It can fold in the global history. It can also fold in each recent target, shifted further right the older that target is. When the execute side finds a mispredicted indirect branch, it sends the corrected target on a separate update port. With that target it sends the same history the branch saw when it was predicted. The update rewrites the target of a way whose tag matches. When no way matches, it places tag and target into a way chosen by a free-running LFSR.

Top module: `itp_top`

## Requirements
- R1: After reset every way is invalid, the response valid flag is low, and any lookup misses until an update has written an entry.
- R2: A lookup request is answered exactly one cycle later. In that cycle the response valid flag is high and the hit flag and target belong to that request.
- R3: The tag is the address bits starting at position ISHIFT (2 by default), TAG_W (16) bits wide. Two addresses that differ only below bit ISHIFT, or only above bit ISHIFT+TAG_W-1, reach the same entry.
- R4: With global-history hashing on, the history is XORed into the shifted address. A history bit below bit log2(SETS) changes the chosen set. A history bit at or above that position does not change it.
- R5: With path hashing on, only the first `count` path slots take part (slot 0 is the newest). Slot p is shifted right by ISHIFT + p*STEP before it is XORed in, where STEP = floor(log2(SETS))/PATH_LEN (2 by default). Slots at or above the count have no effect.
- R6: A lookup hits only on a valid way of the chosen set whose tag matches. On a miss the target output is zero.
- R7: An update whose tag matches a valid way of the chosen set overwrites only that way's target. It does not disturb the other ways of the set.
- R8: An update with no matching way writes its tag and target into one way chosen by the LFSR. A lookup with the same address and history then hits with the new target.
- R9: When an update and a lookup reach the same set in the same cycle, the lookup returns the contents from before the update. The next lookup sees the new contents.
- R10: In a cycle without a lookup request, the following cycle shows response valid low and hit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_ghist | input | GHR_W | Global history for the lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent targets; slot p sits at bits p*ADDR_W upward, slot 0 is newest |
| lk_path_cnt | input | CNT_W | Number of valid path slots |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | A valid way of the set matched the tag |
| rsp_target | output | ADDR_W | Predicted target, zero on miss |
| up_valid | input | 1 | Update request for a mispredicted branch |
| up_pc | input | ADDR_W | Address of the corrected branch |
| up_ghist | input | GHR_W | History the branch saw at prediction time |
| up_path | input | PATH_LEN*ADDR_W | Path history at prediction time, same layout as lk_path |
| up_path_cnt | input | CNT_W | Number of valid update path slots |
| up_target | input | ADDR_W | Corrected target |

## Verification
The lookup path is tested with several kinds of address. One address differs only in its low offset bits and one only above the tag field; both must hit, which shows the tag field is placed correctly. One address shares the set but has a different tag, and it must miss. The history patterns pair a low history bit, which must move the set, with a high one, which must not. The path patterns vary the slot count and place values in older slots that are invisible only under the correct age shift. This separates a design that counts slots correctly and grows the shift with age from one that hashes every slot or shifts all slots alike. Filling two-way sets with three tags, re-updating survivors, and colliding an update with a lookup in one cycle exercises matched overwrite, allocation and read-before-write ordering.

// File: rtl/itp_pkg.sv
package itp_pkg;

  // Per-age shift step used when folding path targets into the set index.
  function automatic int unsigned path_step(int unsigned idx_w, int unsigned plen);
    return (plen == 0) ? 0 : idx_w / plen;
  endfunction

  // Width of a way selector, at least one bit.
  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GHR_W    = 16,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned TAG_W    = 16,
  parameter int unsigned PATH_LEN = 3,
  parameter int unsigned ISHIFT   = 2,
  parameter bit          HASH_GHR = 1'b1,
  parameter bit          HASH_PATH = 1'b1,
  parameter int unsigned CNT_W    = 2
) (
  input  logic [ADDR_W-1:0]          pc,
  input  logic [GHR_W-1:0]           ghist,
  input  logic [PATH_LEN*ADDR_W-1:0] path,
  input  logic [CNT_W-1:0]           path_cnt,
  output logic [IDX_W-1:0]           idx,
  output logic [TAG_W-1:0]           tag
);
  localparam int unsigned STEP = itp_pkg::path_step(IDX_W, PATH_LEN);

  logic [ADDR_W-1:0] ghr_term;
  logic [ADDR_W-1:0] path_term [PATH_LEN];
  logic [ADDR_W-1:0] h;

  if (HASH_GHR) begin : g_ghr_on
    assign ghr_term = ADDR_W'(ghist);
  end else begin : g_ghr_off
    assign ghr_term = '0;
  end

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
    localparam int unsigned SH = ISHIFT + p * STEP;
    if (HASH_PATH) begin : g_on
      assign path_term[p] = (CNT_W'(p) < path_cnt) ?
                            (path[p*ADDR_W +: ADDR_W] >> SH) : '0;
    end else begin : g_off
      assign path_term[p] = '0;
    end
  end

  always_comb begin
    h = (pc >> ISHIFT) ^ ghr_term;
    for (int p = 0; p < PATH_LEN; p++) begin
      h = h ^ path_term[p];
    end
  end

  assign idx = h[IDX_W-1:0];
  assign tag = pc[ISHIFT +: TAG_W];

  logic unused_hash;
  assign unused_hash = ^{h[ADDR_W-1:IDX_W], pc, path, ghist, path_cnt};

endmodule

// File: rtl/itp_lfsr.sv
module itp_lfsr #(
  parameter int unsigned       W    = 16,
  parameter logic [W-1:0]      TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= W'(1);
    end else begin
      st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
    end
  end

  assign state = st_q;

  // A zero state would freeze the victim choice for good.
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
    st_q != '0)
    else $error("lfsr reached all-zero state");

endmodule

// File: rtl/itp_way.sv
module itp_way #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_vld,
  output logic [TAG_W-1:0]  rb_tag,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [ADDR_W-1:0] tgt_mem [SETS];

  // Valid bits need a reset; the payload arrays do not.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign ra_tag = tag_mem[ra_idx];
  assign ra_tgt = tgt_mem[ra_idx];
  assign rb_vld = vld_q[rb_idx];
  assign rb_tag = tag_mem[rb_idx];

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld_q == '0))
    else $error("valid bits not cleared by reset");

  p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> (vld_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)
            && tgt_mem[$past(wr_idx)] == $past(wr_tgt)))
    else $error("written entry not present one cycle later");

endmodule

// File: rtl/itp_top.sv
module itp_top #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GHR_W     = 16,
  parameter int unsigned SETS      = 256,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned PATH_LEN  = 3,
  parameter int unsigned ISHIFT    = 2,
  parameter bit          HASH_GHR  = 1'b1,
  parameter bit          HASH_PATH = 1'b1,
  parameter int unsigned LFSR_W    = 16,
  localparam int unsigned IDX_W    = $clog2(SETS),
  localparam int unsigned CNT_W    = $clog2(PATH_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lk_valid,
  input  logic [ADDR_W-1:0]          lk_pc,
  input  logic [GHR_W-1:0]           lk_ghist,
  input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
  input  logic [CNT_W-1:0]           lk_path_cnt,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [ADDR_W-1:0]          rsp_target,
  input  logic                       up_valid,
  input  logic [ADDR_W-1:0]          up_pc,
  input  logic [GHR_W-1:0]           up_ghist,
  input  logic [PATH_LEN*ADDR_W-1:0] up_path,
  input  logic [CNT_W-1:0]           up_path_cnt,
  input  logic [ADDR_W-1:0]          up_target
);
  localparam int unsigned WAY_W = itp_pkg::sel_width(WAYS);

  if (SETS != (1 << IDX_W)) begin : g_bad_sets
    $error("SETS must be a power of two");
  end

  // Index and tag for both ports
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  itp_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PATH_LEN(PATH_LEN), .ISHIFT(ISHIFT), .HASH_GHR(HASH_GHR),
    .HASH_PATH(HASH_PATH), .CNT_W(CNT_W)
  ) u_hash_lk (
    .pc(lk_pc), .ghist(lk_ghist), .path(lk_path), .path_cnt(lk_path_cnt),
    .idx(lk_idx), .tag(lk_tag)
  );

  itp_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PATH_LEN(PATH_LEN), .ISHIFT(ISHIFT), .HASH_GHR(HASH_GHR),
    .HASH_PATH(HASH_PATH), .CNT_W(CNT_W)
  ) u_hash_up (
    .pc(up_pc), .ghist(up_ghist), .path(up_path), .path_cnt(up_path_cnt),
    .idx(up_idx), .tag(up_tag)
  );

  // Victim source
  logic [LFSR_W-1:0] lfsr;
  itp_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(16'hB400))) u_lfsr (
    .clk(clk), .rst(rst), .state(lfsr)
  );

  // Way storage
  logic [WAYS-1:0]   ra_vld, rb_vld, way_we;
  logic [TAG_W-1:0]  ra_tag [WAYS];
  logic [TAG_W-1:0]  rb_tag [WAYS];
  logic [ADDR_W-1:0] ra_tgt [WAYS];
  logic [WAYS-1:0]   lk_match, up_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    itp_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_way (
      .clk(clk), .rst(rst),
      .ra_idx(lk_idx), .ra_vld(ra_vld[w]), .ra_tag(ra_tag[w]), .ra_tgt(ra_tgt[w]),
      .rb_idx(up_idx), .rb_vld(rb_vld[w]), .rb_tag(rb_tag[w]),
      .we(way_we[w]), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(up_target)
    );
    assign lk_match[w] = ra_vld[w] && (ra_tag[w] == lk_tag);
    assign up_match[w] = rb_vld[w] && (rb_tag[w] == up_tag);
  end

  // Lookup: first matching way supplies the target
  logic              lk_hit;
  logic [ADDR_W-1:0] lk_sel;

  always_comb begin
    lk_sel = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) lk_sel = ra_tgt[w];
    end
  end
  assign lk_hit = |lk_match;

  // Update: matching way, else LFSR victim
  logic [WAY_W-1:0] victim;
  logic [WAYS-1:0]  first_up, victim_oh, wr_oh;

  assign victim = WAY_W'(lfsr % LFSR_W'(WAYS));

  always_comb begin
    first_up = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (up_match[w]) first_up = WAYS'(1) << w;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_vic
    assign victim_oh[w] = (victim == WAY_W'(w));
  end

  assign wr_oh  = (|up_match) ? first_up : victim_oh;
  assign way_we = up_valid ? wr_oh : '0;

  // Registered response
  logic              rsp_valid_q, rsp_hit_q;
  logic [ADDR_W-1:0] rsp_tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_tgt_q   <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      rsp_hit_q   <= lk_valid && lk_hit;
      rsp_tgt_q   <= (lk_valid && lk_hit) ? lk_sel : '0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_target = rsp_tgt_q;

  // A set never holds the same tag twice, so at most one way matches.
  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot0(lk_match))
    else $error("duplicate tag in a set");

  p_update_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> $onehot0(up_match))
    else $error("duplicate tag seen by update");

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_target == '0))
    else $error("target nonzero on miss");

  p_hit_has_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid)
    else $error("hit without response");

endmodule

// File: tb/itp_top_bench.sv
module itp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [15:0] lk_ghist = '0;
  logic [95:0] lk_path = '0;
  logic [1:0]  lk_path_cnt = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_target;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [15:0] up_ghist = '0;
  logic [95:0] up_path = '0;
  logic [1:0]  up_path_cnt = '0;
  logic [31:0] up_target = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itp_top u_itp_top (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_ghist(lk_ghist),
    .lk_path(lk_path), .lk_path_cnt(lk_path_cnt),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_ghist(up_ghist),
    .up_path(up_path), .up_path_cnt(up_path_cnt), .up_target(up_target)
  );

  typedef struct packed {
    logic        upd;
    logic [31:0] pc;
    logic [15:0] gh;
    logic [31:0] p0;
    logic [31:0] p1;
    logic [31:0] p2;
    logic [1:0]  cnt;
    logic [31:0] tgt;
    logic        ehit;
  } vec_t;

  // upd=1: update with tgt; upd=0: lookup expecting {ehit, tgt}
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h0000_1000, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_A000, 1'b0},
    '{1'b0, 32'h0000_1000, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_A000, 1'b1}, // R2
    '{1'b0, 32'h0000_1002, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_A000, 1'b1}, // R3 low bits
    '{1'b0, 32'h0004_1000, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_A000, 1'b1}, // R3 high bits
    '{1'b0, 32'h0000_1000, 16'h0001, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_0000, 1'b0}, // R4 low ghist
    '{1'b0, 32'h0000_1000, 16'h0100, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_A000, 1'b1}, // R4 high ghist
    '{1'b0, 32'h0000_1400, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_0000, 1'b0}, // R6 tag differs
    '{1'b1, 32'h0000_2000, 16'h0000, 32'h40, 32'h0, 32'h0, 2'd1, 32'h0000_B000, 1'b0},
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h0, 32'h0, 2'd1, 32'h0000_B000, 1'b1}, // R5
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h0, 32'h0, 2'd0, 32'h0000_0000, 1'b0}, // R5 count 0
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h777, 32'h999, 2'd1, 32'h0000_B000, 1'b1}, // R5 unused slots
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h0C, 32'h0, 2'd2, 32'h0000_B000, 1'b1}, // R5 slot1 shift 4
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h0C, 32'h3C, 2'd3, 32'h0000_B000, 1'b1}, // R5 slot2 shift 6
    '{1'b0, 32'h0000_2000, 16'h0000, 32'h40, 32'h10, 32'h0, 2'd2, 32'h0000_0000, 1'b0}, // R5 slot1 moves set
    '{1'b1, 32'h0000_1000, 16'h0000, 32'h0, 32'h0, 32'h0, 2'd0, 32'h0000_C000, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Both tasks start and end just after a falling edge.
  task automatic do_update(input logic [31:0] pc, input logic [15:0] gh,
                           input logic [95:0] path, input logic [1:0] cnt,
                           input logic [31:0] tgt);
    up_valid = 1'b1; up_pc = pc; up_ghist = gh; up_path = path;
    up_path_cnt = cnt; up_target = tgt;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] pc, input logic [15:0] gh,
                           input logic [95:0] path, input logic [1:0] cnt,
                           output logic v, output logic h, output logic [31:0] t);
    lk_valid = 1'b1; lk_pc = pc; lk_ghist = gh; lk_path = path; lk_path_cnt = cnt;
    @(negedge clk);
    v = rsp_valid; h = rsp_hit; t = rsp_target;
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic v, h;
    logic [31:0] t;
    int survived;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    do_lookup(32'h0000_1000, 16'h0, '0, 2'd0, v, h, t);
    check("R1 lookup misses after reset", {31'd0, v, h, t}, {31'd0, 1'b1, 1'b0, 32'h0});

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].upd) begin
        do_update(TBL[i].pc, TBL[i].gh, {TBL[i].p2, TBL[i].p1, TBL[i].p0},
                  TBL[i].cnt, TBL[i].tgt);
      end else begin
        do_lookup(TBL[i].pc, TBL[i].gh, {TBL[i].p2, TBL[i].p1, TBL[i].p0},
                  TBL[i].cnt, v, h, t);
        check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), {31'd0, v, h, t},
              {31'd0, 1'b1, TBL[i].ehit, TBL[i].tgt});
      end
    end
    // R7: matched update overwrote the target
    do_lookup(32'h0000_1000, 16'h0, '0, 2'd0, v, h, t);
    check("R7 matched update rewrites target", {32'd0, h, t}, {32'd0, 1'b1, 32'h0000_C000});

    // R10: idle cycle gives no response
    @(negedge clk);
    check("R10 no response without request", {62'd0, rsp_valid, rsp_hit}, 64'd0);

    // R8 / R7: fill two-way sets with three tags
    survived = 0;
    for (int s = 0; s < 8; s++) begin
      logic [31:0] a, b, c;
      a = 32'h0000_3000 + 32'(s + 64) * 4;
      b = a + 32'h400;
      c = a + 32'h800;
      do_update(a, 16'h0, '0, 2'd0, 32'hA100 + 32'(s));
      do_update(b, 16'h0, '0, 2'd0, 32'hB100 + 32'(s));
      do_lookup(b, 16'h0, '0, 2'd0, v, h, t);
      check("R8 newest allocation hits", {32'd0, h, t}, {32'd0, 1'b1, 32'hB100 + 32'(s)});
      do_lookup(a, 16'h0, '0, 2'd0, v, h, t);
      if (h) begin
        survived++;
        check("R8 surviving entry keeps target", {32'd0, t}, {32'd0, 32'hA100 + 32'(s)});
        do_update(a, 16'h0, '0, 2'd0, 32'hA200 + 32'(s));
        do_lookup(a, 16'h0, '0, 2'd0, v, h, t);
        check("R7 matched rewrite", {32'd0, h, t}, {32'd0, 1'b1, 32'hA200 + 32'(s)});
        do_lookup(b, 16'h0, '0, 2'd0, v, h, t);
        check("R7 other way undisturbed", {32'd0, h, t}, {32'd0, 1'b1, 32'hB100 + 32'(s)});
      end
      do_update(c, 16'h0, '0, 2'd0, 32'hC100 + 32'(s));
      do_lookup(c, 16'h0, '0, 2'd0, v, h, t);
      check("R8 third tag allocates", {32'd0, h, t}, {32'd0, 1'b1, 32'hC100 + 32'(s)});
    end
    $display("info: %0d of 8 first entries survived", survived);

    // R9: same-cycle update and lookup on one set
    lk_valid = 1'b1; lk_pc = 32'h0000_3200; lk_ghist = '0; lk_path = '0; lk_path_cnt = '0;
    up_valid = 1'b1; up_pc = 32'h0000_3200; up_ghist = '0; up_path = '0; up_path_cnt = '0;
    up_target = 32'h0000_D000;
    @(negedge clk);
    check("R9 lookup sees old (empty) set", {31'd0, rsp_valid, rsp_hit, rsp_target},
          {31'd0, 1'b1, 1'b0, 32'h0});
    up_target = 32'h0000_D100;
    @(negedge clk);
    check("R9 lookup sees old target", {31'd0, rsp_valid, rsp_hit, rsp_target},
          {31'd0, 1'b1, 1'b1, 32'h0000_D000});
    lk_valid = 1'b0; up_valid = 1'b0;
    do_lookup(32'h0000_3200, 16'h0, '0, 2'd0, v, h, t);
    check("R9 next lookup sees new target", {32'd0, h, t}, {32'd0, 1'b1, 32'h0000_D100});

    // R1: reset again wipes entries
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_lookup(32'h0000_2000, 16'h0, {32'h0, 32'h0, 32'h40}, 2'd1, v, h, t);
    check("R1 reset invalidates entries", {31'd0, v, h, t}, {31'd0, 1'b1, 1'b0, 32'h0});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule